// File: doc/BRIEF.md
# Latched-Time Event Consistency Checker

This block examines acquisition events that arrive one per handshake. Each event holds three consecutive snapshots from three capture channels. Channels 1 and 3 snapshot the same free-running 32-bit time count. Channel 2 snapshots a word that carries a 16-bit event number and two trigger-type flags. For every accepted event the block checks four things. Each time channel must step by exactly one count from snapshot to snapshot. The two time channels must agree within one count. Each channel 2 snapshot must carry exactly one trigger-type flag. The event number must not change across the three snapshots.

The checks only report. They never stall, drop or alter anything. The per-event pass/fail flags and a combined warning come out one cycle after the handshake. Four saturating counters, one for each check class, keep running totals until software pulses the synchronous clear. Event words are packed with snapshot k in bits [32k+31:32k] of each channel bus.

Input rules for the handshake: an event transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and goes high on the first edge after reset is released. It then stays high, so the block never applies back-pressure. A source may hold `in_valid` high on every cycle, and each such cycle is a separate event. The result interface has no ready signal. A result is a single-cycle pulse on `res_valid`.

Top module: `evc_event_checker`

## Requirements
- R1: `in_ready` is low while `rst_n` is low and high from the first clock edge after release. Every cycle with `in_valid` and `in_ready` high yields exactly one `res_valid` pulse on the next cycle, and no other cycle does.
- R2: `fail_cont1` is set when the channel 1 snapshots are not w1 = w0+1 and w2 = w1+1 modulo 2^32, so 0xFFFFFFFF followed by 0x00000000 passes.
- R3: `fail_cont3` applies the same modulo-2^32 continuity rule to channel 3.
- R4: `fail_agree` is set when, for any snapshot index k, ch1[k] minus ch3[k] modulo 2^32 is not 0, 1 or 0xFFFFFFFF.
- R5: `fail_trig` is set when any channel 2 snapshot has other than exactly one of bit 17 (bip flag) and bit 18 (global flag) set. Other upper bits are ignored.
- R6: `fail_evnum` is set when bits [15:0] differ between any of the three channel 2 snapshots. Bits above 15 take no part in this check.
- R7: `warn` is the OR of the five fail flags. All flags and `warn` are low on cycles without `res_valid`.
- R8: The counters are, in order, continuity (ch1 or ch3 failed), agreement, trigger flags and event number. Each counter adds one per event that fails its class, in the same cycle that `res_valid` rises, and holds at 65535.
- R9: `clr_cnt` clears all counters on the next edge and wins over a simultaneous increment. Flag reporting is unaffected.
- R10: After reset, all counters are zero and `res_valid`, the flags and `warn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_cnt | input | 1 | Synchronous clear of all error counters |
| in_valid | input | 1 | Event present on the channel buses |
| in_ready | output | 1 | Block accepts an event |
| ch1_words | input | 96 | Channel 1 time snapshots, word k at [32k+31:32k] |
| ch2_words | input | 96 | Channel 2 snapshots: event number [15:0], bip bit 17, global bit 18 |
| ch3_words | input | 96 | Channel 3 time snapshots |
| res_valid | output | 1 | Result pulse, one cycle after the handshake |
| fail_cont1 | output | 1 | Channel 1 continuity failed |
| fail_cont3 | output | 1 | Channel 3 continuity failed |
| fail_agree | output | 1 | Time channels disagree by more than one count |
| fail_trig | output | 1 | Trigger flags not one-hot |
| fail_evnum | output | 1 | Event number unstable |
| warn | output | 1 | Any check failed |
| cnt_cont | output | 16 | Continuity error count |
| cnt_agree | output | 16 | Agreement error count |
| cnt_trig | output | 16 | Trigger-flag error count |
| cnt_evnum | output | 16 | Event-number error count |

## Verification
A comparator that mishandles wrap or tolerance shows up as a wrong flag on the `res_valid` pulse that follows the event. The vectors therefore place words on both sides of rollover and differences of exactly ±1 and ±2. A counter that loses its place shows up in the same cycle as the flag, and a stuck or wrapping saturation shows up after 65535 failing events. A clear that does not take priority shows up on the cycle after `clr_cnt`.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    CLS_CONT  = 2'd0,
    CLS_AGREE = 2'd1,
    CLS_TRIG  = 2'd2,
    CLS_EVNUM = 2'd3
  } chk_class_e;

  localparam int unsigned NUM_CLS = 4;
endpackage

// File: rtl/evc_time_cont.sv
module evc_time_cont #(
  parameter int unsigned TW      = 32,
  parameter int unsigned N_WORDS = 3
) (
  input  logic [N_WORDS*TW-1:0] words,
  output logic                  ok
);
  localparam int unsigned N_STEPS = N_WORDS - 1;
  logic [N_STEPS-1:0] step_ok;

  for (genvar k = 0; k < N_STEPS; k++) begin : g_step
    logic [TW-1:0] lo_w, hi_w;
    assign lo_w = words[k*TW +: TW];
    assign hi_w = words[(k+1)*TW +: TW];
    // Addition is TW bits wide, so the rollover step compares as adjacent.
    assign step_ok[k] = (hi_w == TW'(lo_w + TW'(1)));
  end

  assign ok = &step_ok;
endmodule

// File: rtl/evc_time_agree.sv
module evc_time_agree #(
  parameter int unsigned TW      = 32,
  parameter int unsigned N_WORDS = 3
) (
  input  logic [N_WORDS*TW-1:0] words_a,
  input  logic [N_WORDS*TW-1:0] words_b,
  output logic                  ok
);
  logic [N_WORDS-1:0] word_ok;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [TW-1:0] diff;
    assign diff = words_a[k*TW +: TW] - words_b[k*TW +: TW];
    assign word_ok[k] = (diff == '0) || (diff == TW'(1)) || (diff == '1);
  end

  assign ok = &word_ok;
endmodule

// File: rtl/evc_tag_check.sv
module evc_tag_check #(
  parameter int unsigned TW       = 32,
  parameter int unsigned N_WORDS  = 3,
  parameter int unsigned EVN_W    = 16,
  parameter int unsigned BIP_BIT  = 17,
  parameter int unsigned GLB_BIT  = 18
) (
  input  logic [N_WORDS*TW-1:0] words,
  output logic                  flags_ok,
  output logic                  evnum_ok
);
  logic [N_WORDS-1:0] one_hot;
  logic [N_WORDS-1:0] same_num;
  logic [EVN_W-1:0]   ref_num;

  assign ref_num = words[EVN_W-1:0];

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic bip_f, glb_f;
    assign bip_f       = words[k*TW + BIP_BIT];
    assign glb_f       = words[k*TW + GLB_BIT];
    assign one_hot[k]  = bip_f ^ glb_f;
    assign same_num[k] = (words[k*TW +: EVN_W] == ref_num);
  end

  assign flags_ok = &one_hot;
  assign evnum_ok = &same_num;
endmodule

// File: rtl/evc_sat_cnt.sv
module evc_sat_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (clr)                      cnt <= '0;
    else if (inc && (cnt != CNT_MAX))  cnt <= cnt + CW'(1);
  end

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + CW'(1));
  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/evc_event_checker.sv
module evc_event_checker
  import evc_pkg::*;
#(
  parameter int unsigned TW      = 32,
  parameter int unsigned N_WORDS = 3,
  parameter int unsigned EVN_W   = 16,
  parameter int unsigned BIP_BIT = 17,
  parameter int unsigned GLB_BIT = 18,
  parameter int unsigned CW      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_cnt,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [N_WORDS*TW-1:0] ch1_words,
  input  logic [N_WORDS*TW-1:0] ch2_words,
  input  logic [N_WORDS*TW-1:0] ch3_words,
  output logic                  res_valid,
  output logic                  fail_cont1,
  output logic                  fail_cont3,
  output logic                  fail_agree,
  output logic                  fail_trig,
  output logic                  fail_evnum,
  output logic                  warn,
  output logic [CW-1:0]         cnt_cont,
  output logic [CW-1:0]         cnt_agree,
  output logic [CW-1:0]         cnt_trig,
  output logic [CW-1:0]         cnt_evnum
);
  localparam int unsigned N_TCH = 2;

  logic                  rdy_q;
  logic                  hs;
  logic [N_WORDS*TW-1:0] tch [N_TCH];
  logic [N_TCH-1:0]      cont_ok;
  logic                  agree_ok, flags_ok, evnum_ok;
  logic [NUM_CLS-1:0]    cls_fail;
  logic [CW-1:0]         cnt_arr [NUM_CLS];

  assign in_ready = rdy_q;
  assign hs       = in_valid && rdy_q;
  assign tch[0]   = ch1_words;
  assign tch[1]   = ch3_words;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  for (genvar c = 0; c < N_TCH; c++) begin : g_cont
    evc_time_cont #(.TW(TW), .N_WORDS(N_WORDS)) u_cont (
      .words (tch[c]),
      .ok    (cont_ok[c])
    );
  end

  evc_time_agree #(.TW(TW), .N_WORDS(N_WORDS)) u_agree (
    .words_a (ch1_words),
    .words_b (ch3_words),
    .ok      (agree_ok)
  );

  evc_tag_check #(
    .TW(TW), .N_WORDS(N_WORDS), .EVN_W(EVN_W),
    .BIP_BIT(BIP_BIT), .GLB_BIT(GLB_BIT)
  ) u_tag (
    .words    (ch2_words),
    .flags_ok (flags_ok),
    .evnum_ok (evnum_ok)
  );

  always_comb begin
    cls_fail            = '0;
    cls_fail[CLS_CONT]  = ~(&cont_ok);
    cls_fail[CLS_AGREE] = ~agree_ok;
    cls_fail[CLS_TRIG]  = ~flags_ok;
    cls_fail[CLS_EVNUM] = ~evnum_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      fail_cont1 <= 1'b0;
      fail_cont3 <= 1'b0;
      fail_agree <= 1'b0;
      fail_trig  <= 1'b0;
      fail_evnum <= 1'b0;
      warn       <= 1'b0;
    end else begin
      res_valid  <= hs;
      fail_cont1 <= hs && !cont_ok[0];
      fail_cont3 <= hs && !cont_ok[1];
      fail_agree <= hs && !agree_ok;
      fail_trig  <= hs && !flags_ok;
      fail_evnum <= hs && !evnum_ok;
      warn       <= hs && (|cls_fail);
    end
  end

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_cnt
    evc_sat_cnt #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_cnt),
      .inc   (hs && cls_fail[i]),
      .cnt   (cnt_arr[i])
    );
  end

  assign cnt_cont  = cnt_arr[CLS_CONT];
  assign cnt_agree = cnt_arr[CLS_AGREE];
  assign cnt_trig  = cnt_arr[CLS_TRIG];
  assign cnt_evnum = cnt_arr[CLS_EVNUM];

  assert_result_follows_hs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);
  assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !res_valid);
  assert_warn_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> res_valid);
  assert_warn_covers_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cont1 || fail_cont3 || fail_agree || fail_trig || fail_evnum) |-> warn);
  assert_cont_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_cnt) && (fail_cont1 || fail_cont3) && $past(cnt_cont) != '1)
      |-> cnt_cont == $past(cnt_cont) + CW'(1));
endmodule

// File: tb/tb_evc_event_checker.sv
`timescale 1ns/1ps
module tb_evc_event_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_cnt = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [95:0] ch1_words = '0, ch2_words = '0, ch3_words = '0;
  logic        res_valid, fail_cont1, fail_cont3, fail_agree, fail_trig, fail_evnum, warn;
  logic [15:0] cnt_cont, cnt_agree, cnt_trig, cnt_evnum;

  always #4 clk = ~clk;

  evc_event_checker dut (
    .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .in_valid(in_valid), .in_ready(in_ready),
    .ch1_words(ch1_words), .ch2_words(ch2_words), .ch3_words(ch3_words),
    .res_valid(res_valid), .fail_cont1(fail_cont1), .fail_cont3(fail_cont3),
    .fail_agree(fail_agree), .fail_trig(fail_trig), .fail_evnum(fail_evnum), .warn(warn),
    .cnt_cont(cnt_cont), .cnt_agree(cnt_agree), .cnt_trig(cnt_trig), .cnt_evnum(cnt_evnum)
  );

  localparam logic [31:0] G = 32'h0004_0000;  // global flag, bit 18
  localparam logic [31:0] B = 32'h0002_0000;  // bip flag, bit 17

  typedef struct packed {
    logic [31:0] a0, a1, a2;   // channel 1
    logic [31:0] c0, c1, c2;   // channel 3
    logic [31:0] t0, t1, t2;   // channel 2
    logic [4:0]  exp;          // {cont1, cont3, agree, trig, evnum}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'd100, 32'd101, 32'd102, 32'd100, 32'd101, 32'd102, G|32'd5, G|32'd5, G|32'd5, 5'b00000},
    '{32'd100, 32'd101, 32'd102, 32'd101, 32'd102, 32'd103, B|32'd7, B|32'd7, B|32'd7, 5'b00000},
    '{32'd100, 32'd101, 32'd102, 32'd99,  32'd100, 32'd101, G|32'd8, G|32'd8, G|32'd8, 5'b00000},
    '{32'hFFFFFFFE, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h1, G|32'hFFFF, G|32'hFFFF, G|32'hFFFF, 5'b00000},
    '{32'd100, 32'd102, 32'd103, 32'd100, 32'd101, 32'd102, G|32'd1, G|32'd1, G|32'd1, 5'b10000},
    '{32'd10,  32'd11,  32'd12,  32'd10,  32'd11,  32'd13,  G|32'd1, G|32'd1, G|32'd1, 5'b01000},
    '{32'd10,  32'd11,  32'd12,  32'd12,  32'd13,  32'd14,  G|32'd1, G|32'd1, G|32'd1, 5'b00100},
    '{32'd0,   32'd1,   32'd2,   32'hFFFFFFFE, 32'hFFFFFFFF, 32'h0, G|32'd1, G|32'd1, G|32'd1, 5'b00100},
    '{32'd10,  32'd11,  32'd12,  32'd10,  32'd11,  32'd12,  G|B|32'd3, G|B|32'd3, G|B|32'd3, 5'b00010},
    '{32'd10,  32'd11,  32'd12,  32'd10,  32'd11,  32'd12,  32'd3, 32'd3, 32'd3, 5'b00010},
    '{32'd10,  32'd11,  32'd12,  32'd10,  32'd11,  32'd12,  G|32'd3, 32'd3, G|32'd3, 5'b00010},
    '{32'd10,  32'd11,  32'd12,  32'd10,  32'd11,  32'd12,  G|32'd3, G|32'd4, G|32'd3, 5'b00001},
    '{32'd10,  32'd11,  32'd12,  32'd10,  32'd11,  32'd12,  G|32'h0001_0003, G|32'd3, G|32'hF000_0003, 5'b00000},
    '{32'd102, 32'd101, 32'd100, 32'd102, 32'd101, 32'd100, B|32'd9, B|32'd9, B|32'd9, 5'b11000}
  };

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt [4] = '{0, 0, 0, 0};
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    chk(req, "cnt_cont",  cnt_cont,  exp_cnt[0]);
    chk(req, "cnt_agree", cnt_agree, exp_cnt[1]);
    chk(req, "cnt_trig",  cnt_trig,  exp_cnt[2]);
    chk(req, "cnt_evnum", cnt_evnum, exp_cnt[3]);
  endtask

  task automatic load(input vec_t v);
    ch1_words = {v.a2, v.a1, v.a0};
    ch3_words = {v.c2, v.c1, v.c0};
    ch2_words = {v.t2, v.t1, v.t0};
  endtask

  task automatic bump(input logic [4:0] e);
    if (e[4] | e[3]) exp_cnt[0] = (exp_cnt[0] < 65535) ? exp_cnt[0] + 1 : 65535;
    if (e[2])        exp_cnt[1] = (exp_cnt[1] < 65535) ? exp_cnt[1] + 1 : 65535;
    if (e[1])        exp_cnt[2] = (exp_cnt[2] < 65535) ? exp_cnt[2] + 1 : 65535;
    if (e[0])        exp_cnt[3] = (exp_cnt[3] < 65535) ? exp_cnt[3] + 1 : 65535;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Reset state (R10, R1)
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", in_ready, 0);
    chk("R10", "res_valid", res_valid, 0);
    chk("R10", "warn", warn, 0);
    chk_counts("R10");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after reset", in_ready, 1);
    chk("R10", "no result idle", res_valid, 0);

    // Table walk (R2..R8)
    foreach (VEC[i]) begin
      load(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      bump(VEC[i].exp);
      chk("R1", $sformatf("res_valid v%0d", i), res_valid, 1);
      chk("R2", $sformatf("fail_cont1 v%0d", i), fail_cont1, VEC[i].exp[4]);
      chk("R3", $sformatf("fail_cont3 v%0d", i), fail_cont3, VEC[i].exp[3]);
      chk("R4", $sformatf("fail_agree v%0d", i), fail_agree, VEC[i].exp[2]);
      chk("R5", $sformatf("fail_trig v%0d", i), fail_trig, VEC[i].exp[1]);
      chk("R6", $sformatf("fail_evnum v%0d", i), fail_evnum, VEC[i].exp[0]);
      chk("R7", $sformatf("warn v%0d", i), warn, |VEC[i].exp);
      chk_counts("R8");
      @(negedge clk);
      chk("R1", "pulse ends", res_valid, 0);
      chk("R7", "flags low idle", {fail_cont1, fail_cont3, fail_agree, fail_trig, fail_evnum, warn}, 0);
    end

    // Clear wins over a simultaneous failing event (R9)
    load(VEC[11]);
    in_valid = 1'b1;
    clr_cnt = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    clr_cnt = 1'b0;
    exp_cnt = '{0, 0, 0, 0};
    chk("R9", "flag kept during clear", fail_evnum, 1);
    chk_counts("R9");

    // Back-to-back events, then saturation (R8)
    load(VEC[11]);
    in_valid = 1'b1;
    repeat (65540) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_cnt[3] = 65535;
    chk_counts("R8");
    @(negedge clk);
    chk("R8", "held at max", cnt_evnum, 65535);

    // Clear from saturation (R9)
    clr_cnt = 1'b1;
    @(negedge clk);
    clr_cnt = 1'b0;
    exp_cnt = '{0, 0, 0, 0};
    chk_counts("R9");

    finish_run();
  end
endmodule